// File: doc/BRIEF.md
# Static RAM Checkerboard March Tester

This controller exercises an external asynchronous byte-wide static RAM through its three active-low strobes (chip select, write enable, output enable) and a shared bidirectional data bus. After a start pulse it first checks each data line on its own at location zero. It then runs a three-pass march over every location. The first pass writes a checkerboard in ascending order. The second pass walks downward, reading each location and then writing the complementary byte. The third pass reads every location in ascending order.

Every read is compared with the byte the sequence expects. The first miscompare is captured together with its address, expected byte and received byte. The run always continues to the end, then reports completion and holds the result until the next start. The address counter, the bus turnaround and the expected-value generation are all inside the block. The test sequence is fixed and is not programmable.

Top module: `sram_march_tester`

## Requirements
- R1: During and after reset, all three strobes are high, the data bus is released (high impedance), and busy, done and fail are low.
- R2: A start pulse while not busy clears the previous result and begins a new run. A start pulse while busy has no effect on the access sequence.
- R3: The data-line test runs first, at address 0, for bit b = 0 up to DATA_W-1. For each bit it writes 0x00, reads, writes a byte with only bit b set, and reads again. Each read compares only bit b.
- R4: Pass 1 writes every address in ascending order. Even addresses get 0xAA (binary 10101010) and odd addresses get 0x55.
- R5: Pass 2 goes from the top address down to 0. At each address it reads first and expects 0xAA at even addresses and 0x55 at odd ones. It then writes 0x55 to even addresses and 0xAA to odd ones.
- R6: Pass 3 reads every address in ascending order and expects 0x55 at even addresses and 0xAA at odd ones. Output enable then stays high.
- R7: Each access has three phases. First comes one setup cycle with output enable high, during which the address may change. Next come STROBE_CYC strobe cycles. Last comes one release cycle. Write enable is low only during the strobe cycles of a write, and the block drives the bus only while write enable is low.
- R8: Read data is sampled only in the last strobe cycle of a read.
- R9: The first miscompare sets a sticky fail flag and records the address, the expected byte and the received byte. Later miscompares do not overwrite this record. For a data-line read, the expected byte is the byte that was written.
- R10: After pass 3, done is asserted and held, and chip select is high, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins a run when not busy |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | inout | DATA_W | Shared data bus |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result valid |
| fail | output | 1 | Sticky miscompare flag |
| fail_addr | output | ADDR_W | Address of first miscompare |
| fail_exp | output | DATA_W | Expected byte at first miscompare |
| fail_got | output | DATA_W | Received byte at first miscompare |

## Verification
A wrong pass, parity or step counter shows up at the RAM pins as soon as the next access starts: the address, the direction or the write byte differs from the arithmetic sequence. So the access log seen at the pins pinpoints the step that went astray. A strobe phase of the wrong length shows up at the same access as a write-enable or output-enable window that is too long or too short. A wrong expected-value or sampling path is invisible on the pins until the end of the run. The bench exposes it with stuck-bit faults and a RAM model whose read data becomes valid only in the last strobe cycle. Either fault yields a wrong or missing record in the fail outputs.

// File: rtl/sram_march_tester.sv
module sram_march_tester #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got
);

  localparam int CW = $clog2(STROBE_CYC + 1);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [ADDR_W-1:0] A_TOP = '1;
  localparam logic [DATA_W-1:0] PAT_A = {(DATA_W/2){2'b10}};
  localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;
  localparam logic [CW-1:0] CNT_END = CW'(STROBE_CYC - 1);
  localparam logic [BW-1:0] BIT_END = BW'(DATA_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_LINE, S_P1, S_P2, S_P3, S_DONE} stage_t;
  typedef enum logic [1:0] {PH_SET, PH_STB, PH_REL} phase_t;

  stage_t            stage;
  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr;
  logic [BW-1:0]     bit_i;
  logic [1:0]        step;
  logic              sub;

  logic              wr;
  logic [DATA_W-1:0] wdata, mask, onehot;
  logic              sample, miss;

  assign onehot = {{(DATA_W-1){1'b0}}, 1'b1} << bit_i;

  always_comb begin
    wr    = 1'b0;
    wdata = '0;
    mask  = '1;
    case (stage)
      S_LINE: begin
        wr    = ~step[0];
        wdata = step[1] ? onehot : '0;
        mask  = onehot;
      end
      S_P1: begin
        wr    = 1'b1;
        wdata = addr[0] ? PAT_B : PAT_A;
      end
      S_P2: begin
        wr    = sub;
        wdata = (addr[0] ^ sub) ? PAT_B : PAT_A;
      end
      S_P3: wdata = addr[0] ? PAT_A : PAT_B;
      default: ;
    endcase
  end

  assign busy     = (stage == S_LINE) || (stage == S_P1) || (stage == S_P2) || (stage == S_P3);
  assign done     = (stage == S_DONE);
  assign mem_addr = addr;
  assign mem_cs_n = ~busy;
  assign mem_oe_n = ~(busy && phase != PH_SET);
  assign mem_we_n = ~(busy && wr && phase == PH_STB);
  assign mem_dq   = mem_we_n ? {DATA_W{1'bz}} : wdata;

  assign sample = busy && !wr && phase == PH_STB && cnt == CNT_END;
  assign miss   = sample && (((mem_dq ^ wdata) & mask) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage     <= S_IDLE;
      phase     <= PH_SET;
      cnt       <= '0;
      addr      <= '0;
      bit_i     <= '0;
      step      <= '0;
      sub       <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else if (!busy) begin
      if (start) begin
        stage     <= S_LINE;
        phase     <= PH_SET;
        addr      <= '0;
        bit_i     <= '0;
        step      <= '0;
        sub       <= 1'b0;
        fail      <= 1'b0;
        fail_addr <= '0;
        fail_exp  <= '0;
        fail_got  <= '0;
      end
    end else begin
      if (miss && !fail) begin
        fail      <= 1'b1;
        fail_addr <= addr;
        fail_exp  <= wdata;
        fail_got  <= mem_dq;
      end
      case (phase)
        PH_SET: begin
          phase <= PH_STB;
          cnt   <= '0;
        end
        PH_STB: begin
          if (cnt == CNT_END) phase <= PH_REL;
          else                cnt   <= cnt + 1'b1;
        end
        default: begin
          phase <= PH_SET;
          case (stage)
            S_LINE: begin
              step <= step + 1'b1;
              if (step == 2'd3) begin
                if (bit_i == BIT_END) begin
                  stage <= S_P1;
                  addr  <= '0;
                end else begin
                  bit_i <= bit_i + 1'b1;
                end
              end
            end
            S_P1: begin
              if (addr == A_TOP) begin
                stage <= S_P2;
                sub   <= 1'b0;
              end else begin
                addr <= addr + 1'b1;
              end
            end
            S_P2: begin
              sub <= ~sub;
              if (sub) begin
                if (addr == '0) stage <= S_P3;
                else            addr  <= addr - 1'b1;
              end
            end
            default: begin
              if (addr == A_TOP) stage <= S_DONE;
              else               addr  <= addr + 1'b1;
            end
          endcase
        end
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_oe_n && mem_we_n));

  p_run_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

  p_we_after_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_oe_n));

  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> (fail && $stable(fail_addr) && $stable(fail_got)));

  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && mem_cs_n));

endmodule

// File: tb/sram_march_tester_tb.sv
module sram_march_tester_tb;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int STB = 3;
  localparam int N   = 1 << AW;
  localparam int TOTAL = 4 * DW + 4 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] addr;
  logic cs_n, we_n, oe_n;
  wire  [DW-1:0] dq;
  logic busy, done, fail;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_exp, f_got;

  always #2.5 clk = ~clk;

  sram_march_tester #(.ADDR_W(AW), .DATA_W(DW), .STROBE_CYC(STB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(addr), .mem_cs_n(cs_n), .mem_we_n(we_n), .mem_oe_n(oe_n),
    .mem_dq(dq), .busy(busy), .done(done), .fail(fail),
    .fail_addr(f_addr), .fail_exp(f_exp), .fail_got(f_got)
  );

  // behavioural RAM: read data valid only in the last strobe cycle, optional stuck bit
  logic [DW-1:0] mem [N];
  int  rd_cnt = 0;
  bit  flt_en = 0;
  int  flt_addr = 0, flt_bit = 0;
  bit  flt_val = 0;

  always @(posedge clk) begin
    if (!oe_n) rd_cnt <= rd_cnt + 1; else rd_cnt <= 0;
    if (!cs_n && !we_n) begin
      logic [DW-1:0] v;
      v = dq;
      if (flt_en && int'(addr) == flt_addr) v[flt_bit] = flt_val;
      mem[addr] <= v;
    end
  end

  assign dq = (!cs_n && !oe_n && we_n) ? ((rd_cnt >= STB-1) ? mem[addr] : ~mem[addr]) : {DW{1'bz}};

  int n_vec = 0, n_miss = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_miss++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic void exp_acc(input int i, output bit wr, output int a, output int d);
    int j;
    if (i < 4*DW) begin
      wr = (i % 4) < 1 || (i % 4) == 2;
      a  = 0;
      d  = ((i % 4) >= 2) ? (1 << (i / 4)) : 0;
    end else if (i < 4*DW + N) begin
      a  = i - 4*DW;
      wr = 1;
      d  = (a % 2) ? 'h55 : 'hAA;
    end else if (i < 4*DW + 3*N) begin
      j  = i - 4*DW - N;
      a  = N - 1 - j / 2;
      wr = j % 2;
      d  = (a % 2) ? 'hAA : 'h55;
    end else begin
      a  = i - 4*DW - 3*N;
      wr = 0;
      d  = 0;
    end
  endfunction

  // access log taken at the pins
  int idx = 0;
  bit prev_oe = 1;
  int oe_len = 0, we_len = 0, acc_addr = 0, acc_data = 0;
  bit acc_wr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!oe_n && prev_oe) begin
        acc_addr = int'(addr); acc_wr = 0; acc_data = 0; oe_len = 0; we_len = 0;
      end
      if (!oe_n) begin
        oe_len++;
        if (int'(addr) != acc_addr) chk(0, "R7", "address moved in strobe", int'(addr), acc_addr);
      end
      if (!we_n) begin
        we_len++; acc_wr = 1; acc_data = int'(dq);
      end
      if (oe_n && !prev_oe) begin
        bit ew; int ea, ed;
        exp_acc(idx, ew, ea, ed);
        chk(oe_len == STB + 1, "R7", "output-enable window", oe_len, STB + 1);
        if (acc_wr) chk(we_len == STB, "R7", "write-enable width", we_len, STB);
        // R3 R4 R5 R6: direction, address, write data at step idx
        chk(acc_wr == ew, idx < 4*DW ? "R3" : "R4-6", "direction", int'(acc_wr), int'(ew));
        chk(acc_addr == ea, idx < 4*DW ? "R3" : "R4-6", "address", acc_addr, ea);
        if (ew && acc_wr) chk(acc_data == ed, idx < 4*DW ? "R3" : "R4-6", "write byte", acc_data, ed);
        idx++;
      end
      prev_oe = oe_n;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run(input bit mid_start);
    idx = 0;
    pulse_start();
    chk(busy && !done && !fail, "R2", "started, result cleared", {busy, done, fail}, 3'b100);
    if (mid_start) begin
      repeat (150) @(negedge clk);
      pulse_start();
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(idx == TOTAL, "R2", "access count", idx, TOTAL);
    chk(oe_n && we_n && !busy, "R6", "output enable high after pass 3", {oe_n, we_n, busy}, 3'b110);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(cs_n && we_n && oe_n, "R1", "strobes in reset", {cs_n, we_n, oe_n}, 3'b111);
    chk(!busy && !done && !fail, "R1", "flags in reset", {busy, done, fail}, 0);
    chk(dq === {DW{1'bz}}, "R1", "bus released", int'(dq), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // clean run with a start pulse while busy (R2), reads valid only late (R8)
    run(1);
    chk(!fail, "R8", "clean run passes", int'(fail), 0);
    for (int a = 0; a < N; a++)
      chk(mem[a] == ((a % 2) ? 8'hAA : 8'h55), "R5", "final content", int'(mem[a]), (a % 2) ? 'hAA : 'h55);
    repeat (10) @(negedge clk);
    chk(done && cs_n && oe_n, "R10", "done held, chip deselected", {done, cs_n, oe_n}, 3'b111);

    // stuck-at-1 on bit 3 of address 5: first hit in pass 2 read
    flt_en = 1; flt_addr = 5; flt_bit = 3; flt_val = 1;
    run(0);
    chk(fail, "R9", "fail flag", int'(fail), 1);
    chk(f_addr == 5, "R9", "fail address", int'(f_addr), 5);
    chk(f_exp == 8'h55, "R5", "fail expected", int'(f_exp), 'h55);
    chk(f_got == 8'h5D, "R9", "fail received", int'(f_got), 'h5D);

    // stuck-at-0 on bit 2 of address 0: data-line test catches it first, pass 3 again later
    flt_addr = 0; flt_bit = 2; flt_val = 0;
    run(0);
    chk(fail && f_addr == 0, "R3", "line fail address", int'(f_addr), 0);
    chk(f_exp == 8'h04, "R9", "line fail expected (first kept)", int'(f_exp), 'h04);
    chk(f_got == 8'h00, "R9", "line fail received (first kept)", int'(f_got), 'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_miss++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule